// File: doc/BRIEF.md
# Programmable Video Timing Generator

The block produces the raster timing for a display path: an active-low horizontal sync, an active-low vertical sync, an active-high data enable, and the current pixel position within the line and line position within the frame. Software programs the horizontal and vertical timing through a plain write port. Each axis has four parts, played in a fixed order: sync, back porch, active, front porch. The line length is the sum of the four horizontal parts. The frame length in lines is the sum of the four vertical parts.

Timing values first land in shadow registers. They reach the working set only after an update strobe, and then only at the first pixel of the next frame. A frame can therefore never mix old and new timing. Every horizontal quantity is rounded up to an even pixel count. A colour source drives the pixel outputs during data enable. It can output black, eight vertical colour bars, or a fixed programmable colour.

Each axis is a small state machine with the states IDLE, SYNC, BACK, ACT and FRONT. When a segment's last count is reached, the machine moves to the next segment of nonzero length in circular order SYNC, BACK, ACT, FRONT. If every other segment is zero, that search comes back to the current segment. A load of new timing sends the machine to the first nonzero segment of the new set, or to IDLE if all four are zero. IDLE is left only by such a load. The horizontal machine steps every clock. The vertical machine steps on the last pixel of each line.

Top module: `vtg_top`

## Requirements
- R1: Writes go to shadow registers and do not change any output until an update is applied. The addresses are:
  - 0: horizontal back porch in [31:16], horizontal sync width in [15:0].
  - 1: horizontal front porch in [31:16], active width in [15:0].
  - 2: vertical back porch in [31:16], vertical sync lines in [15:0].
  - 3: vertical front porch in [31:16], active lines in [15:0].
- R2: Writing address 4 with bit 0 set requests one update, and the request clears itself. The shadow set becomes the working set at the clock edge that ends the last pixel of the current frame, so the next pixel is pixel 0 of line 0 under the new timing. If the working timing is idle, the copy happens on the edge after the request is registered.
- R3: hsync_n is low for the first (rounded) sync-width pixels of every line, starting at h_count 0, and high otherwise.
- R4: de is high exactly when h_count lies in [sync+back, sync+back+active) of the line and v_count lies in the same window of the frame.
- R5: Each of the four horizontal values is rounded up to the next even number before use. Vertical values are used as written.
- R6: vsync_n is low during the first vertical-sync lines of each frame, starting at v_count 0, and high otherwise.
- R7: h_count runs 0 to line total minus 1 and wraps. v_count steps by one when h_count wraps and itself wraps at the frame total.
- R8: A segment of length zero takes no cycles and no lines. The total is still the sum of the four parts.
- R9: While either the line total or the frame total of the working set is zero, the outputs are held at hsync_n=1, vsync_n=1, de=0, h_count=0, v_count=0 and all colour channels 0.
- R10: Address 5 sets the colour source, and a write takes effect on the next pixel. The mode field is [1:0]: 0 is black, 1 is bars, 2 or 3 is solid. The solid colour is red [31:24], green [23:16], blue [15:8]. All colour channels are 0 whenever de is low.
- R11: In bar mode the bar width w is the rounded active width divided by 8, with a minimum of 1. Pixel offset a within the active region gets index i = min(a / w, 7). With c = 7 - i, red is 255 when c bit 2 is set, green when c bit 1 is set, and blue when c bit 0 is set; each channel is 0 otherwise.
- R12: After reset the working and shadow timing are all zero and the colour mode is black, so the outputs are in the R9 idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high |
| h_count | output | 19 | Pixel position within the line |
| v_count | output | 19 | Line position within the frame |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |

## Verification
The bench reprograms the timing in the middle of a frame and then strobes an update.
- If the copy were applied at once instead of at the frame boundary, the old frame would be cut short.
- If the update were lost, the following frames would keep the old length.

Odd horizontal values check the rounding: a design that skipped it would give one-pixel-short sync and active widths. A configuration with an empty back porch and an empty front porch checks that zero segments are skipped rather than held for a full counter wrap. A return to all-zero timing checks that the outputs go quiet instead of toggling through a degenerate line. The bar pattern, sampled pixel by pixel, shows whether the bar counter restarts on every line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int FIELD_W = 16;
    localparam int LEN_W   = FIELD_W + 1;
    localparam int POS_W   = FIELD_W + 3;
    localparam int PIX_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int NSEG    = 4;
    localparam int NBARS   = 8;
    localparam int BAR_SH  = $clog2(NBARS);

    localparam logic [ADDR_W-1:0] A_HTIM_A  = 3'd0;
    localparam logic [ADDR_W-1:0] A_HTIM_B  = 3'd1;
    localparam logic [ADDR_W-1:0] A_VTIM_A  = 3'd2;
    localparam logic [ADDR_W-1:0] A_VTIM_B  = 3'd3;
    localparam logic [ADDR_W-1:0] A_UPDATE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PATTERN = 3'd5;

    // segment indices inside a length vector
    localparam int IX_SYNC  = 0;
    localparam int IX_BACK  = 1;
    localparam int IX_ACT   = 2;
    localparam int IX_FRONT = 3;

    typedef enum logic [2:0] {
        SEG_IDLE  = 3'd0,
        SEG_SYNC  = 3'd1,
        SEG_BACK  = 3'd2,
        SEG_ACT   = 3'd3,
        SEG_FRONT = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        PAT_OFF   = 2'd0,
        PAT_BARS  = 2'd1,
        PAT_SOLID = 2'd2,
        PAT_ALT   = 2'd3
    } pat_e;

    typedef logic [NSEG-1:0][LEN_W-1:0] seg_lens_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output logic              load,
    output seg_lens_t         h_work,
    output seg_lens_t         v_work,
    output seg_lens_t         h_next,
    output seg_lens_t         v_next,
    output logic [POS_W-1:0]  h_tot,
    output logic [POS_W-1:0]  v_tot,
    output pat_e              pat_mode,
    output logic [3*PIX_W-1:0] solid_rgb
);
    logic [NSEG-1:0][FIELD_W-1:0] sh_h;
    logic [NSEG-1:0][FIELD_W-1:0] sh_v;
    logic pending;
    logic work_run;
    logic unused_data_bits;

    assign unused_data_bits = ^wr_data[PIX_W-1:2];

    // shadow to next-set: horizontal rounded up to even, vertical as is
    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            h_next[i] = {1'b0, sh_h[i]} + {{FIELD_W{1'b0}}, sh_h[i][0]};
            v_next[i] = {1'b0, sh_v[i]};
        end
    end

    always_comb begin
        h_tot = '0;
        v_tot = '0;
        for (int i = 0; i < NSEG; i++) begin
            h_tot = h_tot + POS_W'(h_work[i]);
            v_tot = v_tot + POS_W'(v_work[i]);
        end
    end

    assign work_run = (h_tot != '0) && (v_tot != '0);
    assign load     = pending && (!work_run || frame_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_h      <= '0;
            sh_v      <= '0;
            pat_mode  <= PAT_OFF;
            solid_rgb <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_HTIM_A: begin
                    sh_h[IX_BACK] <= wr_data[31:16];
                    sh_h[IX_SYNC] <= wr_data[15:0];
                end
                A_HTIM_B: begin
                    sh_h[IX_FRONT] <= wr_data[31:16];
                    sh_h[IX_ACT]   <= wr_data[15:0];
                end
                A_VTIM_A: begin
                    sh_v[IX_BACK] <= wr_data[31:16];
                    sh_v[IX_SYNC] <= wr_data[15:0];
                end
                A_VTIM_B: begin
                    sh_v[IX_FRONT] <= wr_data[31:16];
                    sh_v[IX_ACT]   <= wr_data[15:0];
                end
                A_PATTERN: begin
                    pat_mode  <= pat_e'(wr_data[1:0]);
                    solid_rgb <= wr_data[31:8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            h_work  <= '0;
            v_work  <= '0;
        end else begin
            if (load) begin
                pending <= 1'b0;
                h_work  <= h_next;
                v_work  <= v_next;
            end
            if (wr_en && (wr_addr == A_UPDATE) && wr_data[0])
                pending <= 1'b1;
        end
    end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  seg_lens_t        lens,
    input  seg_lens_t        nlens,
    output seg_e             seg,
    output logic [POS_W-1:0] pos,
    output logic             last,
    output logic             in_sync,
    output logic             in_act,
    output logic             idle
);
    seg_e             seg_n;
    logic [LEN_W-1:0] cnt, cnt_n, cur_len;
    logic [POS_W-1:0] pos_n, tot;
    int               cur_ix;

    function automatic seg_e seg_of(input int ix);
        seg_e r;
        unique case (ix)
            IX_SYNC: r = SEG_SYNC;
            IX_BACK: r = SEG_BACK;
            IX_ACT:  r = SEG_ACT;
            default: r = SEG_FRONT;
        endcase
        return r;
    endfunction

    // first nonzero segment after 'from' in circular order
    function automatic seg_e pick_after(input int from, input seg_lens_t l);
        seg_e r;
        int   j;
        r = SEG_IDLE;
        for (int k = NSEG; k >= 1; k--) begin
            j = (from + NSEG + k) % NSEG;
            if (l[j] != '0) r = seg_of(j);
        end
        return r;
    endfunction

    always_comb begin
        tot = '0;
        for (int i = 0; i < NSEG; i++) tot = tot + POS_W'(lens[i]);
    end

    always_comb begin
        unique case (seg)
            SEG_SYNC:  begin cur_ix = IX_SYNC;  cur_len = lens[IX_SYNC];  end
            SEG_BACK:  begin cur_ix = IX_BACK;  cur_len = lens[IX_BACK];  end
            SEG_ACT:   begin cur_ix = IX_ACT;   cur_len = lens[IX_ACT];   end
            SEG_FRONT: begin cur_ix = IX_FRONT; cur_len = lens[IX_FRONT]; end
            default:   begin cur_ix = -1;       cur_len = '0;             end
        endcase
    end

    assign last = (seg != SEG_IDLE) && (pos == tot - 1'b1);

    // next-state logic
    always_comb begin
        seg_n = seg;
        cnt_n = cnt;
        pos_n = pos;
        if (load) begin
            seg_n = pick_after(-1, nlens);
            cnt_n = '0;
            pos_n = '0;
        end else if ((seg != SEG_IDLE) && adv) begin
            if (cnt == cur_len - 1'b1) begin
                seg_n = pick_after(cur_ix, lens);
                cnt_n = '0;
            end else begin
                cnt_n = cnt + 1'b1;
            end
            pos_n = last ? '0 : pos + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg <= SEG_IDLE;
            cnt <= '0;
            pos <= '0;
        end else begin
            seg <= seg_n;
            cnt <= cnt_n;
            pos <= pos_n;
        end
    end

    // outputs
    always_comb begin
        in_sync = 1'b0;
        in_act  = 1'b0;
        idle    = 1'b0;
        unique case (seg)
            SEG_IDLE:  idle    = 1'b1;
            SEG_SYNC:  in_sync = 1'b1;
            SEG_ACT:   in_act  = 1'b1;
            SEG_BACK, SEG_FRONT: ;
            default:   idle    = 1'b1;
        endcase
    end
endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               h_act,
    input  logic               h_last,
    input  logic               de,
    input  pat_e               mode,
    input  logic [3*PIX_W-1:0] solid_rgb,
    input  logic [LEN_W-1:0]   act_len,
    output logic [PIX_W-1:0]   pix_r,
    output logic [PIX_W-1:0]   pix_g,
    output logic [PIX_W-1:0]   pix_b
);
    logic [LEN_W-1:0]  bar_w, bar_cnt;
    logic [BAR_SH-1:0] bar_ix, bar_code;

    assign bar_w = ((act_len >> BAR_SH) == '0) ? LEN_W'(1) : (act_len >> BAR_SH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bar_cnt <= '0;
            bar_ix  <= '0;
        end else if (load || !h_act || h_last) begin
            bar_cnt <= '0;
            bar_ix  <= '0;
        end else if ((bar_cnt == bar_w - 1'b1) && (bar_ix != {BAR_SH{1'b1}})) begin
            bar_cnt <= '0;
            bar_ix  <= bar_ix + 1'b1;
        end else begin
            bar_cnt <= bar_cnt + 1'b1;
        end
    end

    assign bar_code = ~bar_ix;

    always_comb begin
        pix_r = '0;
        pix_g = '0;
        pix_b = '0;
        if (de) begin
            unique case (mode)
                PAT_OFF: ;
                PAT_BARS: begin
                    pix_r = {PIX_W{bar_code[2]}};
                    pix_g = {PIX_W{bar_code[1]}};
                    pix_b = {PIX_W{bar_code[0]}};
                end
                PAT_SOLID, PAT_ALT: begin
                    pix_r = solid_rgb[3*PIX_W-1:2*PIX_W];
                    pix_g = solid_rgb[2*PIX_W-1:PIX_W];
                    pix_b = solid_rgb[PIX_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [POS_W-1:0]  h_count,
    output logic [POS_W-1:0]  v_count,
    output logic [PIX_W-1:0]  pix_r,
    output logic [PIX_W-1:0]  pix_g,
    output logic [PIX_W-1:0]  pix_b
);
    seg_lens_t          h_work, v_work, h_next, v_next;
    logic [POS_W-1:0]   h_tot, v_tot, h_pos, v_pos;
    logic               load, frame_end, running;
    logic               h_last, v_last, h_sync, v_sync, h_act, v_act, h_idle, v_idle;
    seg_e               h_seg, v_seg;
    pat_e               pat_mode;
    logic [3*PIX_W-1:0] solid_rgb;

    vtg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .load      (load),
        .h_work    (h_work),
        .v_work    (v_work),
        .h_next    (h_next),
        .v_next    (v_next),
        .h_tot     (h_tot),
        .v_tot     (v_tot),
        .pat_mode  (pat_mode),
        .solid_rgb (solid_rgb)
    );

    vtg_axis u_h_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (1'b1),
        .load    (load),
        .lens    (h_work),
        .nlens   (h_next),
        .seg     (h_seg),
        .pos     (h_pos),
        .last    (h_last),
        .in_sync (h_sync),
        .in_act  (h_act),
        .idle    (h_idle)
    );

    vtg_axis u_v_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (h_last),
        .load    (load),
        .lens    (v_work),
        .nlens   (v_next),
        .seg     (v_seg),
        .pos     (v_pos),
        .last    (v_last),
        .in_sync (v_sync),
        .in_act  (v_act),
        .idle    (v_idle)
    );

    assign running   = !h_idle && !v_idle;
    assign frame_end = h_last && v_last;

    assign hsync_n = !(running && h_sync);
    assign vsync_n = !(running && v_sync);
    assign de      = running && h_act && v_act;
    assign h_count = running ? h_pos : '0;
    assign v_count = running ? v_pos : '0;

    vtg_pattern u_pattern (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .h_act     (h_act),
        .h_last    (h_last),
        .de        (de),
        .mode      (pat_mode),
        .solid_rgb (solid_rgb),
        .act_len   (h_work[IX_ACT]),
        .pix_r     (pix_r),
        .pix_g     (pix_g),
        .pix_b     (pix_b)
    );
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
    import vtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             frame_end,
    input logic [POS_W-1:0] h_tot,
    input logic [POS_W-1:0] v_tot,
    input logic [LEN_W-1:0] h_sync_len,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic             de,
    input logic [POS_W-1:0] h_count,
    input logic [PIX_W-1:0] pix_r,
    input logic [PIX_W-1:0] pix_g,
    input logic [PIX_W-1:0] pix_b
);
    logic cfg_run;
    assign cfg_run = (h_tot != '0) && (v_tot != '0);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |-> (hsync_n && vsync_n && !de && h_count == '0));

    // R2
    load_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!cfg_run || frame_end));

    // R3
    hsync_at_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && h_count == '0 && h_sync_len != '0) |-> !hsync_n);

    // R4
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));

    // R7
    pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_run && !load && h_count != h_tot - 1'b1) |=> (h_count == $past(h_count) + 1'b1));

    // R10
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_r == '0 && pix_g == '0 && pix_b == '0));
endmodule

bind vtg_top vtg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .frame_end  (frame_end),
    .h_tot      (h_tot),
    .v_tot      (v_tot),
    .h_sync_len (h_work[0]),
    .hsync_n    (hsync_n),
    .vsync_n    (vsync_n),
    .de         (de),
    .h_count    (h_count),
    .pix_r      (pix_r),
    .pix_g      (pix_g),
    .pix_b      (pix_b)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_n, vsync_n, de;
    logic [18:0] h_count, v_count;
    logic [7:0]  pix_r, pix_g, pix_b;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit cyc_chk = 1'b0;

    vtg_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .h_count(h_count), .v_count(v_count),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    int sh_h[4], sh_v[4], wh[4], wv[4];
    int m_hp, m_vp, m_mode, m_rgb;
    bit m_pend;

    function automatic int rnd_even(input int x);
        return x + (x & 1);
    endfunction

    function automatic int sum4(input int a, input int b, input int c, input int d);
        return a + b + c + d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                sh_h[i] = 0; sh_v[i] = 0; wh[i] = 0; wv[i] = 0;
            end
            m_hp = 0; m_vp = 0; m_mode = 0; m_rgb = 0; m_pend = 0;
        end else begin
            int ht, vt;
            bit run, ld;
            ht  = sum4(wh[0], wh[1], wh[2], wh[3]);
            vt  = sum4(wv[0], wv[1], wv[2], wv[3]);
            run = (ht != 0) && (vt != 0);
            ld  = m_pend && (!run || (m_hp == ht - 1 && m_vp == vt - 1));
            if (ld) begin
                for (int i = 0; i < 4; i++) begin
                    wh[i] = rnd_even(sh_h[i]);
                    wv[i] = sh_v[i];
                end
                m_hp = 0; m_vp = 0;
                m_pend = 0;
            end else if (run) begin
                if (m_hp == ht - 1) begin
                    m_hp = 0;
                    m_vp = (m_vp == vt - 1) ? 0 : m_vp + 1;
                end else begin
                    m_hp = m_hp + 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin sh_h[1] = int'(wr_data[31:16]); sh_h[0] = int'(wr_data[15:0]); end
                    3'd1: begin sh_h[3] = int'(wr_data[31:16]); sh_h[2] = int'(wr_data[15:0]); end
                    3'd2: begin sh_v[1] = int'(wr_data[31:16]); sh_v[0] = int'(wr_data[15:0]); end
                    3'd3: begin sh_v[3] = int'(wr_data[31:16]); sh_v[2] = int'(wr_data[15:0]); end
                    3'd4: if (wr_data[0]) m_pend = 1;
                    3'd5: begin m_mode = int'(wr_data[1:0]); m_rgb = int'(wr_data[31:8]); end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && cyc_chk) begin
            int ht, vt, a0, a1, v0, v1, er, eg, eb, ax, bw, bi, bc;
            bit run, hact, vact, ede;
            ht = sum4(wh[0], wh[1], wh[2], wh[3]);
            vt = sum4(wv[0], wv[1], wv[2], wv[3]);
            run = (ht != 0) && (vt != 0);
            a0 = wh[0] + wh[1]; a1 = a0 + wh[2];
            v0 = wv[0] + wv[1]; v1 = v0 + wv[2];
            hact = (m_hp >= a0) && (m_hp < a1);
            vact = (m_vp >= v0) && (m_vp < v1);
            ede = run && hact && vact;
            chk("R3", "hsync_n", int'(hsync_n), (run && m_hp < wh[0]) ? 0 : 1);
            chk("R6", "vsync_n", int'(vsync_n), (run && m_vp < wv[0]) ? 0 : 1);
            chk("R4", "de", int'(de), int'(ede));
            chk("R7", "h_count", int'(h_count), run ? m_hp : 0);
            chk("R7", "v_count", int'(v_count), run ? m_vp : 0);
            er = 0; eg = 0; eb = 0;
            if (ede && m_mode == 1) begin
                ax = m_hp - a0;
                bw = wh[2] / 8;
                if (bw == 0) bw = 1;
                bi = ax / bw;
                if (bi > 7) bi = 7;
                bc = 7 - bi;
                er = (bc & 4) ? 255 : 0;
                eg = (bc & 2) ? 255 : 0;
                eb = (bc & 1) ? 255 : 0;
                chk("R11", "bar rgb", int'({pix_r, pix_g, pix_b}), (er << 16) | (eg << 8) | eb);
            end else begin
                if (ede && m_mode >= 2) begin
                    er = (m_rgb >> 16) & 255; eg = (m_rgb >> 8) & 255; eb = m_rgb & 255;
                end
                chk("R10", "rgb", int'({pix_r, pix_g, pix_b}), (er << 16) | (eg << 8) | eb);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic prog(input int hs, input int hb, input int ha, input int hf,
                        input int vs, input int vb, input int va, input int vf);
        wr(3'd0, {hb[15:0], hs[15:0]});
        wr(3'd1, {hf[15:0], ha[15:0]});
        wr(3'd2, {vb[15:0], vs[15:0]});
        wr(3'd3, {vf[15:0], va[15:0]});
    endtask

    task automatic idle_outputs(input string tag, input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            chk(tag, "idle hsync_n", int'(hsync_n), 1);
            chk(tag, "idle vsync_n", int'(vsync_n), 1);
            chk(tag, "idle de", int'(de), 0);
            chk(tag, "idle counts", int'(h_count) + int'(v_count), 0);
            chk(tag, "idle rgb", int'({pix_r, pix_g, pix_b}), 0);
            @(negedge clk);
        end
    endtask

    // waits for pixel 0 of line 0, then counts one frame
    task automatic measure(output int len, output int hs_lo, output int vs_lo, output int de_hi);
        int guard;
        guard = 0;
        while (!(h_count == 0 && v_count == 0 && !hsync_n) && guard < 50000) begin
            @(negedge clk); guard++;
        end
        len = 0; hs_lo = 0; vs_lo = 0; de_hi = 0;
        do begin
            hs_lo += int'(!hsync_n);
            vs_lo += int'(!vsync_n);
            de_hi += int'(de);
            len++;
            @(negedge clk);
        end while (!(h_count == 0 && v_count == 0) && len < 50000);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int len, hsl, vsl, deh;
        repeat (4) @(negedge clk);
        // R12 reset state, checked while reset is still applied
        chk("R12", "reset hsync_n", int'(hsync_n), 1);
        chk("R12", "reset vsync_n", int'(vsync_n), 1);
        chk("R12", "reset de", int'(de), 0);
        chk("R12", "reset rgb", int'({pix_r, pix_g, pix_b}), 0);
        rst_n = 1'b1;
        cyc_chk = 1'b1;
        @(negedge clk);
        idle_outputs("R9", 10);

        // config A: odd horizontal values get rounded (2,2,20,4 -> 28), vertical 1,1,3,1 -> 6
        prog(1, 2, 19, 3, 1, 1, 3, 1);
        wr(3'd5, 32'h0000_0001);
        idle_outputs("R1", 20);
        wr(3'd4, 32'h1);
        measure(len, hsl, vsl, deh);
        chk("R2", "frame A length", len, 28 * 6);
        chk("R5", "hsync low per frame A", hsl, 2 * 6);
        chk("R6", "vsync low per frame A", vsl, 28 * 1);
        chk("R5", "de per frame A", deh, 20 * 3);
        measure(len, hsl, vsl, deh);
        chk("R7", "second frame A length", len, 28 * 6);
        chk("R4", "second frame A de", deh, 20 * 3);

        // mid-frame reprogramming with empty back porch and empty vertical front porch
        while (v_count != 2) @(negedge clk);
        prog(2, 0, 16, 2, 2, 1, 2, 0);
        chk("R1", "shadow write leaves line total", int'(h_count) < 28 ? 1 : 0, 1);
        wr(3'd4, 32'h1);
        measure(len, hsl, vsl, deh);
        chk("R2", "frame B length", len, 20 * 5);
        chk("R3", "hsync low per frame B", hsl, 2 * 5);
        chk("R8", "de per frame B", deh, 16 * 2);
        wr(3'd5, 32'h7814_6302);
        measure(len, hsl, vsl, deh);
        chk("R8", "second frame B length", len, 20 * 5);
        chk("R6", "vsync low per frame B", vsl, 20 * 2);
        repeat (30) @(negedge clk);

        // back to all-zero timing
        prog(0, 0, 0, 0, 0, 0, 0, 0);
        wr(3'd4, 32'h1);
        repeat (120) @(negedge clk);
        idle_outputs("R9", 30);

        cyc_chk = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule